// File: doc/BRIEF.md
# Video Stream Framing Monitor

A passive observer for a valid/ready video stream that carries one pixel per beat, a start-of-frame marker on bit 0 of the user sideband and an end-of-line marker on the last signal. It never drives the ready signal and never alters data. It only watches accepted beats. It counts the position of each beat within its line and the number of lines within a frame. The first line of each frame sets the expected line width. The monitor then flags lines that end too early, lines that run past the expected width, and frame markers that arrive anywhere other than at the start of a line.

Each error is a sticky bit that stays set until a clear pulse. On every frame marker that closes a frame, the measured width and height of that frame are registered and shown on the outputs. Traffic that arrives before the first frame marker after reset is ignored and raises its own flag.

Top module: `vfm_top`

## Requirements
- R1: A beat is accepted only on a rising edge where `valid_i`, `ready_i` and `clk_en_i` are all high. Any other cycle changes no output and no internal count.
- R2: The position of the first end-of-line beat after a frame marker becomes the expected width of that frame.
- R3: An end-of-line beat at a position below the expected width sets `err_o[0]` (early end-of-line).
- R4: An accepted beat without end-of-line that reaches the expected width sets `err_o[1]` (late end-of-line). The flag appears after that beat and not after any earlier one. Counting continues until the end-of-line marker arrives, and the line after it is checked normally.
- R5: A frame marker on a beat that is not the first beat of a line sets `err_o[2]`. A line starts after reset or after an end-of-line beat. That beat restarts the line and frame counts, so the next frame is measured from it.
- R6: A frame marker held high for two consecutive accepted beats sets `err_o[2]`, unless the first of the two beats also ended a line.
- R7: Accepted beats after reset and before the first frame marker do not count, and each one sets `err_o[3]`.
- R8: On a frame marker that follows an earlier one, `width_o` takes the width learned in the closing frame and `height_o` takes the number of end-of-line beats in that frame. `meas_valid_o` goes high and stays high.
- R9: Error bits stay set until `clear_i` is high at a clock edge. If a new error occurs on the same edge as the clear, the new error is kept.
- R10: After reset, `err_o`, `width_o`, `height_o` and `meas_valid_o` are all zero.
- R11: A beat that carries both the frame marker and end-of-line is a line of width 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stream clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable of the stream |
| valid_i | input | 1 | Observed valid |
| ready_i | input | 1 | Observed ready |
| user_i | input | USER_W | Observed user sideband; bit 0 is the frame marker |
| last_i | input | 1 | Observed end-of-line marker |
| clear_i | input | 1 | Clears the sticky error bits |
| err_o | output | 4 | Sticky errors: bit0 early, bit1 late, bit2 misplaced frame marker, bit3 missing frame marker |
| width_o | output | PIX_W | Width of the last closed frame |
| height_o | output | LINE_W | Line count of the last closed frame |
| meas_valid_o | output | 1 | At least one frame has closed |

## Verification
The bench builds the monitor with its default parameters: 12-bit pixel position, 11-bit line count and a 2-bit user sideband. These widths leave every flag path reachable with frames of a few short lines. Single-pixel lines, late lines that are later closed, and back-to-back frame markers can all be driven in a few dozen cycles. Stalls made through ready and through the clock enable are placed inside frames, so the measured width and height show whether such a cycle was counted. Saturation of the counters is out of reach at these widths.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  localparam int ERR_N      = 4;
  localparam int ERR_EARLY  = 0;
  localparam int ERR_LATE   = 1;
  localparam int ERR_MIDSOF = 2;
  localparam int ERR_NOSOF  = 3;
endpackage

// File: rtl/vfm_pos_track.sv
module vfm_pos_track #(
  parameter int PIX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sof_i,
  input  logic             eol_i,
  output logic             frame_beat_o,
  output logic             in_frame_o,
  output logic [PIX_W-1:0] pos_o,
  output logic             mid_sof_o,
  output logic             no_sof_o
);
  logic             in_frame_q;
  logic             line_start_q;
  logic [PIX_W-1:0] pix_cnt_q;
  logic [PIX_W-1:0] pix_inc;

  assign pix_inc      = (pix_cnt_q == '1) ? pix_cnt_q : pix_cnt_q + 1'b1;
  assign frame_beat_o = beat_i & (sof_i | in_frame_q);
  assign in_frame_o   = in_frame_q;
  assign pos_o        = (sof_i | line_start_q) ? PIX_W'(1) : pix_inc;
  assign mid_sof_o    = beat_i & sof_i & ~line_start_q;
  assign no_sof_o     = beat_i & ~sof_i & ~in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q   <= 1'b0;
      line_start_q <= 1'b1;
      pix_cnt_q    <= '0;
    end else if (frame_beat_o) begin
      in_frame_q <= 1'b1;
      if (eol_i) begin
        line_start_q <= 1'b1;
        pix_cnt_q    <= '0;
      end else begin
        line_start_q <= 1'b0;
        pix_cnt_q    <= pos_o;
      end
    end
  end

  // R5
  line_start_after_eol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_beat_o && eol_i) |=> line_start_q);

  // R7
  ignored_beat_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_sof_o |=> ($stable(pix_cnt_q) && !in_frame_q));
endmodule

// File: rtl/vfm_line_meas.sv
module vfm_line_meas #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_beat_i,
  input  logic              sof_i,
  input  logic              eol_i,
  input  logic              in_frame_i,
  input  logic [PIX_W-1:0]  pos_i,
  output logic              early_o,
  output logic              late_o,
  output logic [PIX_W-1:0]  width_o,
  output logic [LINE_W-1:0] height_o,
  output logic              meas_valid_o
);
  logic              known_q;
  logic [PIX_W-1:0]  learned_q;
  logic [LINE_W-1:0] lines_q;
  logic              known_eff;
  logic [LINE_W-1:0] lines_base;
  logic [LINE_W-1:0] lines_inc;

  // a frame marker discards what the closing frame learned
  assign known_eff  = known_q & ~sof_i;
  assign lines_base = sof_i ? '0 : lines_q;
  assign lines_inc  = (lines_base == '1) ? lines_base : lines_base + 1'b1;

  assign early_o = frame_beat_i & eol_i & known_eff & (pos_i < learned_q);
  assign late_o  = frame_beat_i & ~eol_i & known_eff & (pos_i == learned_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      known_q   <= 1'b0;
      learned_q <= '0;
      lines_q   <= '0;
    end else if (frame_beat_i) begin
      if (eol_i) begin
        lines_q <= lines_inc;
        if (!known_eff) begin
          known_q   <= 1'b1;
          learned_q <= pos_i;
        end
      end else if (sof_i) begin
        known_q <= 1'b0;
        lines_q <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o      <= '0;
      height_o     <= '0;
      meas_valid_o <= 1'b0;
    end else if (frame_beat_i && sof_i && in_frame_i) begin
      width_o      <= known_q ? learned_q : '0;
      height_o     <= lines_q;
      meas_valid_o <= 1'b1;
    end
  end

  // R8
  height_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_beat_i && sof_i) |=> $stable(height_o));

  // R8
  meas_valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_valid_o |=> meas_valid_o);

  // R2
  width_learned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_beat_i && eol_i && !known_eff) |=> (known_q && learned_q == $past(pos_i)));
endmodule

// File: rtl/vfm_err_sticky.sv
module vfm_err_sticky #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clear_i,
  output logic [N-1:0] err_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        err_o[g] <= 1'b0;
      else if (set_i[g])  err_o[g] <= 1'b1;
      else if (clear_i)   err_o[g] <= 1'b0;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((err_o & $past(err_o)) == $past(err_o)));

  // R9
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && set_i == '0) |=> (err_o == '0));
endmodule

// File: rtl/vfm_top.sv
module vfm_top
  import vfm_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11,
  parameter int USER_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [USER_W-1:0] user_i,
  input  logic              last_i,
  input  logic              clear_i,
  output logic [ERR_N-1:0]  err_o,
  output logic [PIX_W-1:0]  width_o,
  output logic [LINE_W-1:0] height_o,
  output logic              meas_valid_o
);
  logic             beat;
  logic             sof;
  logic             frame_beat;
  logic             in_frame;
  logic [PIX_W-1:0] pos;
  logic             mid_sof;
  logic             no_sof;
  logic             early;
  logic             late;
  logic [ERR_N-1:0] err_set;

  assign beat = valid_i & ready_i & clk_en_i;
  assign sof  = user_i[0];

  vfm_pos_track #(.PIX_W(PIX_W)) u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_i       (beat),
    .sof_i        (sof),
    .eol_i        (last_i),
    .frame_beat_o (frame_beat),
    .in_frame_o   (in_frame),
    .pos_o        (pos),
    .mid_sof_o    (mid_sof),
    .no_sof_o     (no_sof)
  );

  vfm_line_meas #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_meas (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_beat_i (frame_beat),
    .sof_i        (sof),
    .eol_i        (last_i),
    .in_frame_i   (in_frame),
    .pos_i        (pos),
    .early_o      (early),
    .late_o       (late),
    .width_o      (width_o),
    .height_o     (height_o),
    .meas_valid_o (meas_valid_o)
  );

  always_comb begin
    err_set             = '0;
    err_set[ERR_EARLY]  = early;
    err_set[ERR_LATE]   = late;
    err_set[ERR_MIDSOF] = mid_sof;
    err_set[ERR_NOSOF]  = no_sof;
  end

  vfm_err_sticky #(.N(ERR_N)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (err_set),
    .clear_i (clear_i),
    .err_o   (err_o)
  );

  // R1
  idle_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat && !clear_i) |=> ($stable(err_o) && $stable(width_o) && $stable(height_o)));
endmodule

// File: tb/vfm_top_tb_top.sv
module vfm_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic        valid = 1'b0;
  logic        ready = 1'b0;
  logic [1:0]  user = '0;
  logic        last = 1'b0;
  logic        clear = 1'b0;
  logic [3:0]  err;
  logic [11:0] width;
  logic [10:0] height;
  logic        meas_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfm_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .valid_i(valid),
    .ready_i(ready), .user_i(user), .last_i(last), .clear_i(clear),
    .err_o(err), .width_o(width), .height_o(height), .meas_valid_o(meas_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one accepted beat; outputs sampled on the following falling edge
  task automatic beat(input bit s, input bit e, input bit clr = 0);
    valid = 1; ready = 1; clk_en = 1; user = {1'b0, s}; last = e; clear = clr;
    @(negedge clk);
    valid = 0; user = '0; last = 0; clear = 0;
  endtask

  task automatic line(input int n, input bit s);
    for (int i = 1; i <= n; i++) beat(s && i == 1, i == n);
  endtask

  task automatic do_clear();
    clear = 1; @(negedge clk); clear = 0;
  endtask

  task automatic t_reset();
    chk("R10 err", err, 0);
    chk("R10 width", width, 0);
    chk("R10 height", height, 0);
    chk("R10 meas_valid", meas_valid, 0);
  endtask

  task automatic t_no_sof();
    beat(0, 0); beat(0, 1); beat(0, 0);
    chk("R7 missing marker flag", err, 4'b1000);
    do_clear();
    chk("R9 clear", err, 0);
    line(3, 1);
    // stray beats did not count: first line is width 3
    line(3, 0);
    beat(1, 0);
    chk("R7 width after ignored beats", width, 3);
    chk("R8 height", height, 2);
    chk("R7 no other error", err, 0);
    line(2, 0); // close the open line (width 3 learned? no: new frame)
  endtask

  task automatic t_normal();
    do_clear();
    line(4, 1); line(4, 0); line(4, 0);
    beat(1, 0);
    chk("R2 width", width, 4);
    chk("R8 height", height, 3);
    chk("R8 meas_valid", meas_valid, 1);
    chk("R2 no error", err, 0);
    beat(0, 1);
  endtask

  task automatic t_stall();
    do_clear();
    beat(1, 0);
    valid = 1; ready = 0; clk_en = 1; last = 1; @(negedge clk);
    valid = 1; ready = 1; clk_en = 0; last = 1; @(negedge clk);
    valid = 0; clk_en = 1; last = 0;
    chk("R1 stalled eol ignored", err, 0);
    beat(0, 0); beat(0, 0); beat(0, 0); beat(0, 1);
    valid = 1; ready = 0; user = 2'b01; @(negedge clk);
    valid = 0; user = '0;
    line(5, 0);
    beat(1, 0);
    chk("R1 width with stalls", width, 5);
    chk("R1 height with stalls", height, 2);
    chk("R1 no error", err, 0);
    beat(0, 1);
  endtask

  task automatic t_early();
    do_clear();
    line(4, 1); line(3, 0);
    chk("R3 early flag", err, 4'b0001);
  endtask

  task automatic t_late();
    do_clear();
    line(4, 1);
    beat(0, 0); beat(0, 0); beat(0, 0);
    chk("R4 no flag before width", err, 0);
    beat(0, 0);
    chk("R4 late flag", err, 4'b0010);
    beat(0, 0); beat(0, 1);
    do_clear();
    line(4, 0);
    chk("R4 next line checked normally", err, 0);
    beat(1, 0);
    chk("R4 width kept", width, 4);
    chk("R8 height with long line", height, 3);
    beat(0, 1);
  endtask

  task automatic t_mid_sof();
    do_clear();
    line(4, 1);
    beat(0, 0); beat(0, 0); beat(1, 0);
    chk("R5 misplaced marker", err, 4'b0100);
    do_clear();
    beat(0, 0); beat(0, 1); // line from marker: width 3
    line(3, 0);
    beat(1, 0);
    chk("R5 restart width", width, 3);
    chk("R5 restart height", height, 2);
    chk("R5 no early after restart", err, 0);
    beat(0, 1);
  endtask

  task automatic t_double_sof();
    do_clear();
    beat(1, 0); beat(1, 0);
    chk("R6 held marker", err, 4'b0100);
    beat(0, 1);
  endtask

  task automatic t_single_pixel();
    do_clear();
    beat(1, 1); beat(0, 1); beat(0, 1);
    chk("R11 no error", err, 0);
    beat(1, 1);
    chk("R11 width 1", width, 1);
    chk("R11 height", height, 3);
    chk("R6 marker after eol is legal", err, 0);
  endtask

  task automatic t_clear_race();
    do_clear();
    line(2, 1);
    beat(0, 0);
    beat(0, 0, 1); // reaches width without eol while clearing
    chk("R9 set wins over clear", err, 4'b0010);
    do_clear();
    chk("R9 cleared", err, 0);
    beat(0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_sof();
    t_normal();
    t_stall();
    t_early();
    t_late();
    t_mid_sof();
    t_double_sof();
    t_single_pixel();
    t_clear_race();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule